// File: doc/BRIEF.md
# One-Way Lock and OTP Merge Unit

This unit sits on the path from a page-write request to a memory array that stores four bytes per page. Every write request is classified against a small set of one-way state: a 16-bit lock vector and a 32-bit one-time-programmable (OTP) word. Requests to protected or locked pages are refused. Requests to the lock page and the OTP page are turned into bitwise OR merges that can set bits but never clear them. All other requests pass through unchanged.

The lock vector is indexed by page number. Bits 3 to 15 each make one page read-only. Bits 0 to 2 are block-lock bits, and each one freezes a group of the page lock bits. The lock vector is held in bytes 2 and 3 of page 2: byte 2 holds vector bits 7..0 and byte 3 holds bits 15..8. The data word puts byte k on bits 8k+7..8k. One clock after a request, the unit presents a registered array write (page, byte enables, data) and an ACK or NAK result. A separate combinational port tells other logic whether a given page would currently refuse a write. Each merge is applied in one cycle, so it is atomic.

Top module: `lkm_merge_unit`

## Requirements
- R1: After reset the lock vector and the OTP word are all zeros. `arr_we` and `resp_valid` are low, and pages 3 to 15 are not locked.
- R2: A request sampled on a clock edge produces `resp_valid` high on the next cycle, with `resp_ack` 1 for ACK and 0 for NAK. `arr_we` is high in exactly the cycles where `resp_ack` is high, and `arr_page` gives the requested page.
- R3: Pages 0 and 1 always return NAK. A page at or above `NUM_PAGES` (default 20) also returns NAK.
- R4: A write to page 2 returns ACK with `arr_be` = 4'b1100. `arr_wdata[31:16]` holds the merged lock vector and `arr_wdata[15:0]` is zero. Data bytes 0 and 1 of the request have no effect.
- R5: For pages 3 to 15, when lock vector bit p is 1, page p returns NAK and the array is not written.
- R6: Block-lock bit 0 freezes lock bit 3. Bit 1 freezes lock bits 4 to 9. Bit 2 freezes lock bits 10 to 15. The freeze uses the vector as stored before the write, so a single write can set a block-lock bit and a lock bit it covers.
- R7: A write to page 2 ORs its bytes 2 and 3 into the lock vector. Lock bits are never cleared.
- R8: A write to page 3 that is not locked returns ACK with `arr_be` = 4'b1111 and `arr_wdata` equal to the old OTP word ORed with the data. The OTP word keeps that value.
- R9: A write to any other unlocked, in-range page returns ACK with `arr_be` = 4'b1111 and `arr_wdata` equal to the request data.
- R10: A lock bit set by one write refuses a write to its page in the very next cycle.
- R11: `qry_locked` is combinational and equals the NAK rule of R3 and R5 applied to `qry_page` and the current lock vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request strobe |
| wr_page | input | PAGE_W | Requested page |
| wr_data | input | 32 | Request data, byte k on bits 8k+7..8k |
| qry_page | input | PAGE_W | Page for the lock query |
| qry_locked | output | 1 | Page would refuse a write now |
| arr_we | output | 1 | Array write enable |
| arr_page | output | PAGE_W | Array page address |
| arr_be | output | 4 | Array byte enables |
| arr_wdata | output | 32 | Array write data after merge |
| resp_valid | output | 1 | Result valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NAK |

## Verification
The bench first targets the freeze boundaries. Vector bits 5, 8 and 9 fall under block-lock bit 1, bits 10 to 15 under bit 2, and bit 3 under bit 0. A design that sampled the new block-lock value instead of the old one would drop the page 11 lock that arrives in the same write as its block-lock bit. Back-to-back requests check that a lock just set refuses the next write; a design that used a delayed copy of the lock vector would ACK that write. Repeated writes of zeros check that no bit clears, and the bench checks that byte 0 and byte 1 are masked on page 2. A long random sequence is compared against a reference model of the lock and OTP state.

// File: rtl/lkm_pkg.sv
package lkm_pkg;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned BYTES_PER_PAGE = 4;
  localparam int unsigned DATA_W         = BYTE_W * BYTES_PER_PAGE;
  localparam int unsigned LOCK_VEC_W     = 16;
  localparam int unsigned SERIAL_PAGES   = 2;
  localparam int unsigned LOCK_PAGE      = 2;
  localparam int unsigned OTP_PAGE       = 3;
  localparam int unsigned FIRST_LOCKABLE = 3;
  localparam int unsigned LAST_LOCKABLE  = 15;
  localparam int unsigned NUM_BLOCKS     = 3;

  typedef enum logic [1:0] {
    WK_REJECT = 2'd0,
    WK_LOCK   = 2'd1,
    WK_OTP    = 2'd2,
    WK_PLAIN  = 2'd3
  } wr_kind_e;

  // Page lock bits that a given block-lock field holds frozen
  function automatic logic [LOCK_VEC_W-1:0] freeze_mask(input logic [NUM_BLOCKS-1:0] bl);
    logic [LOCK_VEC_W-1:0] m;
    m = '0;
    for (int i = 0; i < LOCK_VEC_W; i++) begin
      if (i == 3)                m[i] = bl[0];
      else if (i >= 4 && i <= 9) m[i] = bl[1];
      else if (i >= 10)          m[i] = bl[2];
    end
    return m;
  endfunction
endpackage

// File: rtl/lkm_page_decode.sv
module lkm_page_decode
  import lkm_pkg::*;
#(
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned NUM_PAGES = 20
) (
  input  logic [PAGE_W-1:0]     page,
  input  logic [LOCK_VEC_W-1:0] lock_vec,
  output logic                  locked,
  output wr_kind_e              kind
);
  localparam int unsigned CMP_W = PAGE_W + 1;

  logic in_range, serial, lockable, lock_hit;
  logic [3:0] bit_idx;

  always_comb begin
    in_range = ({1'b0, page} < CMP_W'(NUM_PAGES));
    serial   = (page < PAGE_W'(SERIAL_PAGES));
    lockable = (page >= PAGE_W'(FIRST_LOCKABLE)) && (page <= PAGE_W'(LAST_LOCKABLE));
    bit_idx  = page[3:0];
    lock_hit = lockable && lock_vec[bit_idx];
    locked   = !in_range || serial || lock_hit;
    if (locked)                          kind = WK_REJECT;
    else if (page == PAGE_W'(LOCK_PAGE)) kind = WK_LOCK;
    else if (page == PAGE_W'(OTP_PAGE))  kind = WK_OTP;
    else                                 kind = WK_PLAIN;
  end
endmodule

// File: rtl/lkm_lock_bank.sv
module lkm_lock_bank
  import lkm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd,
  input  logic [LOCK_VEC_W-1:0] din,
  output logic [LOCK_VEC_W-1:0] merged,
  output logic [LOCK_VEC_W-1:0] lock_q
);
  logic [LOCK_VEC_W-1:0] frz;

  always_comb begin
    frz    = freeze_mask(lock_q[NUM_BLOCKS-1:0]);
    merged = lock_q | (din & ~frz);
  end

  always_ff @(posedge clk) begin
    if (rst)      lock_q <= '0;
    else if (upd) lock_q <= merged;
  end
endmodule

// File: rtl/lkm_otp_reg.sv
module lkm_otp_reg
  import lkm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] otp_q
);
  assign merged = otp_q | din;

  always_ff @(posedge clk) begin
    if (rst)      otp_q <= '0;
    else if (upd) otp_q <= merged;
  end
endmodule

// File: rtl/lkm_merge_unit.sv
module lkm_merge_unit
  import lkm_pkg::*;
#(
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned NUM_PAGES = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_req,
  input  logic [PAGE_W-1:0]         wr_page,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [PAGE_W-1:0]         qry_page,
  output logic                      qry_locked,
  output logic                      arr_we,
  output logic [PAGE_W-1:0]         arr_page,
  output logic [BYTES_PER_PAGE-1:0] arr_be,
  output logic [DATA_W-1:0]         arr_wdata,
  output logic                      resp_valid,
  output logic                      resp_ack
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [LOCK_VEC_W-1:0] lock_vec, lock_merged;
  logic [DATA_W-1:0]     otp_q, otp_merged;
  logic                  wr_locked, accept;
  wr_kind_e              wr_kind, qry_kind;

  lkm_page_decode #(.PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)) u_wdec (
    .page(wr_page), .lock_vec(lock_vec), .locked(wr_locked), .kind(wr_kind));

  lkm_page_decode #(.PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES)) u_qdec (
    .page(qry_page), .lock_vec(lock_vec), .locked(qry_locked), .kind(qry_kind));

  assign accept = wr_req && !wr_locked;

  lkm_lock_bank u_lock (
    .clk(clk), .rst(rst), .upd(accept && wr_kind == WK_LOCK),
    .din(wr_data[DATA_W-1:HALF_W]), .merged(lock_merged), .lock_q(lock_vec));

  lkm_otp_reg u_otp (
    .clk(clk), .rst(rst), .upd(accept && wr_kind == WK_OTP),
    .din(wr_data), .merged(otp_merged), .otp_q(otp_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we     <= 1'b0;
      arr_page   <= '0;
      arr_be     <= '0;
      arr_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
    end else begin
      arr_we     <= accept;
      resp_valid <= wr_req;
      resp_ack   <= accept;
      if (wr_req) begin
        arr_page <= wr_page;
        unique case (wr_kind)
          WK_LOCK: begin
            arr_be    <= 4'b1100;
            arr_wdata <= {lock_merged, {HALF_W{1'b0}}};
          end
          WK_OTP: begin
            arr_be    <= '1;
            arr_wdata <= otp_merged;
          end
          WK_PLAIN: begin
            arr_be    <= '1;
            arr_wdata <= wr_data;
          end
          default: begin
            arr_be    <= '0;
            arr_wdata <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lkm_merge_chk.sv
module lkm_merge_chk
  import lkm_pkg::*;
#(
  parameter int unsigned PAGE_W = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_req,
  input logic [PAGE_W-1:0]         wr_page,
  input logic                      resp_valid,
  input logic                      resp_ack,
  input logic                      arr_we,
  input logic [BYTES_PER_PAGE-1:0] arr_be,
  input logic [LOCK_VEC_W-1:0]     lock_q,
  input logic [DATA_W-1:0]         otp_q
);
  // R2
  we_matches_ack_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (arr_we == resp_ack));

  // R2
  no_we_without_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !arr_we);

  // R3
  serial_nak_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_page < PAGE_W'(SERIAL_PAGES)) |=> (resp_valid && !resp_ack));

  // R4
  lock_page_be_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_page == PAGE_W'(LOCK_PAGE)) |=> (resp_ack && arr_be == 4'b1100));

  // R7
  lock_never_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R8
  otp_never_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ((otp_q & $past(otp_q)) == $past(otp_q)));

  // R6
  upper_group_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q[2] |=> $stable(lock_q[15:10]));

  // R6
  mid_group_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q[1] |=> $stable(lock_q[9:4]));
endmodule

bind lkm_merge_unit lkm_merge_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_req(wr_req), .wr_page(wr_page),
  .resp_valid(resp_valid), .resp_ack(resp_ack), .arr_we(arr_we),
  .arr_be(arr_be), .lock_q(lock_vec), .otp_q(otp_q));

// File: tb/sim_lkm_merge_unit.sv
`timescale 1ns/1ps
module sim_lkm_merge_unit;
  localparam int PW = 6;
  localparam int NP = 20;
  localparam int NV = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_req = 1'b0;
  logic [PW-1:0] wr_page = '0;
  logic [31:0]   wr_data = '0;
  logic [PW-1:0] qry_page = '0;
  logic          qry_locked, arr_we, resp_valid, resp_ack;
  logic [PW-1:0] arr_page;
  logic [3:0]    arr_be;
  logic [31:0]   arr_wdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] lockm;
  logic [31:0] otpm;

  always #5 clk = ~clk;

  lkm_merge_unit #(.PAGE_W(PW), .NUM_PAGES(NP)) u0 (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_page(wr_page), .wr_data(wr_data),
    .qry_page(qry_page), .qry_locked(qry_locked), .arr_we(arr_we),
    .arr_page(arr_page), .arr_be(arr_be), .arr_wdata(arr_wdata),
    .resp_valid(resp_valid), .resp_ack(resp_ack));

  // {page, data, expected ack}
  localparam logic [38:0] VEC [NV] = '{
    {6'd0,  32'hDEADBEEF, 1'b0}, {6'd1,  32'h01020304, 1'b0},
    {6'd4,  32'h11223344, 1'b1}, {6'd3,  32'h00000005, 1'b1},
    {6'd3,  32'h00000102, 1'b1}, {6'd2,  32'h0010FFFF, 1'b1},
    {6'd4,  32'h55555555, 1'b0}, {6'd5,  32'hA5A5A5A5, 1'b1},
    {6'd2,  32'h00020000, 1'b1}, {6'd2,  32'h03200000, 1'b1},
    {6'd5,  32'h00000001, 1'b1}, {6'd2,  32'h04000000, 1'b1},
    {6'd10, 32'h00000001, 1'b0}, {6'd20, 32'h00000001, 1'b0},
    {6'd19, 32'hCAFEF00D, 1'b1}, {6'd2,  32'h00010000, 1'b1},
    {6'd2,  32'h00080000, 1'b1}, {6'd3,  32'h80000000, 1'b1},
    {6'd2,  32'h08040000, 1'b1}, {6'd11, 32'h00000001, 1'b0},
    {6'd2,  32'h10000000, 1'b1}, {6'd12, 32'h00000001, 1'b1},
    {6'd7,  32'h00000001, 1'b1}, {6'd8,  32'h00000001, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_locked(input int p);
    return (p < 2) || (p >= NP) || (p >= 3 && p <= 15 && lockm[p]);
  endfunction

  function automatic logic [15:0] model_frz(input logic [15:0] v);
    logic [15:0] m = '0;
    m[3] = v[0];
    for (int i = 4; i <= 9; i++) m[i] = v[1];
    for (int i = 10; i <= 15; i++) m[i] = v[2];
    return m;
  endfunction

  function automatic string tag_of(input int p, input logic ack);
    if (p < 2 || p >= NP) return "R3";
    if (p == 2) return "R4";
    if (!ack) return "R5";
    if (p == 3) return "R8";
    return "R9";
  endfunction

  // Drives one request for one cycle and checks the registered result
  task automatic apply(input int p, input logic [31:0] d, output logic got_ack);
    logic        e_ack;
    logic [3:0]  e_be;
    logic [31:0] e_w;
    string       t;
    e_ack = !model_locked(p);
    e_be = 4'hF;
    e_w = d;
    if (e_ack && p == 2) begin
      lockm = lockm | (d[31:16] & ~model_frz(lockm));
      e_be = 4'b1100;
      e_w = {lockm, 16'h0};
    end else if (e_ack && p == 3) begin
      otpm = otpm | d;
      e_w = otpm;
    end
    wr_req = 1'b1;
    wr_page = PW'(p);
    wr_data = d;
    @(negedge clk);
    t = tag_of(p, e_ack);
    got_ack = resp_ack;
    chk(resp_valid == 1'b1, "R2", {31'd0, resp_valid}, 32'd1);
    chk(arr_we == resp_ack, "R2", {31'd0, arr_we}, {31'd0, resp_ack});
    chk(resp_ack == e_ack, t, {31'd0, resp_ack}, {31'd0, e_ack});
    if (e_ack) begin
      chk(arr_page == PW'(p), "R2", {26'd0, arr_page}, p);
      chk(arr_be == e_be, t, {28'd0, arr_be}, {28'd0, e_be});
      chk(arr_wdata == e_w, t, arr_wdata, e_w);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_req = 1'b0;
    lockm = '0;
    otpm = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic query(input int p, input logic exp, input string req);
    qry_page = PW'(p);
    #1;
    chk(qry_locked == exp, req, {31'd0, qry_locked}, {31'd0, exp});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk(resp_valid == 1'b0, "R1", {31'd0, resp_valid}, 0);
    chk(arr_we == 1'b0, "R1", {31'd0, arr_we}, 0);
    for (int p = 3; p <= 15; p++) query(p, 1'b0, "R1");
    query(0, 1'b1, "R11");

    // Vector table walked back to back
    for (int i = 0; i < NV; i++) begin
      apply(int'(VEC[i][38:33]), VEC[i][32:1], a);
      chk(a == VEC[i][0], (i == 6) ? "R10" : tag_of(int'(VEC[i][38:33]), VEC[i][0]),
          {31'd0, a}, {31'd0, VEC[i][0]});
    end
    // R6 R7: zero write shows frozen and kept bits
    apply(2, 32'h0000ABCD, a);
    chk(arr_wdata == 32'h0C170000, "R6", arr_wdata, 32'h0C170000);
    chk(arr_wdata[15:0] == 16'h0, "R4", {16'd0, arr_wdata[15:0]}, 0);
    apply(2, 32'h00000000, a);
    chk(arr_wdata[31:16] == 16'h0C17, "R7", {16'd0, arr_wdata[31:16]}, 32'h0C17);
    apply(3, 32'h00000000, a);
    chk(arr_wdata == 32'h80000107, "R8", arr_wdata, 32'h80000107);
    wr_req = 1'b0;
    @(negedge clk);
    chk(resp_valid == 1'b0, "R2", {31'd0, resp_valid}, 0);
    // R11: query port
    query(4, 1'b1, "R11");
    query(5, 1'b0, "R11");
    query(11, 1'b1, "R11");
    query(2, 1'b0, "R11");
    query(21, 1'b1, "R11");

    // R1 R10: reset then back-to-back lock
    do_reset();
    @(negedge clk);
    query(6, 1'b0, "R1");
    apply(3, 32'h00000000, a);
    chk(arr_wdata == 32'h0, "R1", arr_wdata, 0);
    apply(6, 32'h12345678, a);
    apply(2, 32'h00400000, a);
    apply(6, 32'h12345678, a);
    chk(a == 1'b0, "R10", {31'd0, a}, 0);
    apply(2, 32'h00000000, a);
    chk(arr_wdata[31:16] == 16'h0040, "R7", {16'd0, arr_wdata[31:16]}, 32'h40);

    // Random sequence against the model
    for (int k = 0; k < 400; k++) begin
      apply(int'($urandom_range(0, 23)), $urandom & $urandom & $urandom, a);
    end
    wr_req = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 24; p++) query(p, model_locked(p), "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule